// File: doc/BRIEF.md
# External Bus Sequencer with Idle-State Insertion

This block turns single requests from a CPU-side master into external bus cycles. Each request carries an address, a read or write flag and two byte enables. The top three address bits pick one of eight areas, and each area has its own active-low select. Area 2 holds DRAM. Area 5 is a slow static area that takes one extra state. Every other area is a plain two-state static area. The sequencer drives the address, the selects, a read strobe and two byte write strobes. During DRAM cycles the two write strobes serve as the upper and lower column strobes.

Requests can follow each other with no gap. The next access then starts on the clock edge that ends the previous one. When a read is followed at once by an access to another area, the read strobe of the old cycle rises on the same edge as the new cycle's select falls. Board delays can turn that shared edge into a short overlap. Two configuration bits can each insert one idle state at that point. One covers a read followed by a read. The other covers a read followed by a write. No idle state is inserted in any other case.

Top module: `xbus_idle_seq`

## Requirements
- R1: When a read is followed back to back by a read to a different area, exactly one idle state is inserted between them if `cfgIdleRR` is 1, and none is inserted if it is 0. The setting of `cfgIdleWR` has no effect on this case.
- R2: When a read is followed back to back by a write to a different area, exactly one idle state is inserted between them if `cfgIdleWR` is 1, and none is inserted if it is 0. The setting of `cfgIdleRR` has no effect on this case.
- R3: No idle state is inserted in any of these cases, whatever the configuration: the next access targets the same area, the previous access was a write, or the request is taken while the bus is idle.
- R4: When no idle state is inserted, the new access's first state directly follows the previous access's final state. The old read strobe is still low in that final state and is released on the edge where the new select asserts.
- R5: During an idle state, all selects, the read strobe and both write strobes are high, and the address keeps the value of the previous access.
- R6: A static access runs the states T1 then T2. Area 5 adds a third state, T3. The area's select is low in all of these states. For a read, the read strobe is low in all of them. For a write, a write strobe is low from the second state onward: `wrHiN` when enable bit 1 is set, and `wrLoN` when enable bit 0 is set.
- R7: A DRAM access (area 2) runs precharge, row, first column and second column, in that order. The address is driven from precharge onward. The area select stays high in precharge and is low from the row state onward. In both column states the write strobes act as column strobes, following the byte enables as in R6, for reads and for writes alike. For a read, the read strobe is low in both column states.
- R8: The idle state of R1 also applies when a static-area read is followed by a DRAM read. It is inserted ahead of the precharge state.
- R9: `reqGrant` is high while the bus is idle and during the final state of each access, and low in every other state. A request is taken on the edge where `reqValid` and `reqGrant` are both high. Its first state, or its idle state, starts in the next cycle.
- R10: After reset, `reqGrant` is 1, all strobes and selects are high, and the address is 0.
- R11: The area is the top three address bits. Select bit n belongs to area n, and at most one select is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgIdleRR | input | 1 | Insert an idle state for a read followed by a read to another area |
| cfgIdleWR | input | 1 | Insert an idle state for a read followed by a write to another area |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Request address; bits 23..21 select the area |
| reqBe | input | 2 | Byte enables; bit 1 = upper byte, bit 0 = lower byte |
| reqGrant | output | 1 | Request is taken at the coming edge if `reqValid` is high |
| busAddr | output | 24 | External address |
| csN | output | 8 | Area selects, active low |
| rdN | output | 1 | Read strobe, active low |
| wrHiN | output | 1 | Upper byte write strobe, or upper column strobe in DRAM |
| wrLoN | output | 1 | Lower byte write strobe, or lower column strobe in DRAM |

## Verification
A wrong state register, or a wrong idle decision, shows up within one cycle of the bad decision. The next select falls one cycle early or late, or the address changes during what should be a held idle cycle. Because of this, the bench times the first low select of the second request relative to the first request's final state, for every combination of the configuration bits and access type. A corrupted latched request shows up as the wrong select bit or the wrong byte strobe within the same access.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_TI, S_T1, S_T2, S_T3, S_TP, S_TR, S_TC1, S_TC2
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic driveAddr;
    logic csOn;
    logic rdOn;
    logic wrOn;
  } busStrobe_t;

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AREA_W = 3,
  parameter logic [(1<<AREA_W)-1:0] DRAM_MASK = 8'h04,
  parameter logic [(1<<AREA_W)-1:0] SLOW_MASK = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgIdleRR,
  input  logic              cfgIdleWR,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [AREA_W-1:0] newArea,
  input  logic [AREA_W-1:0] curArea,
  input  logic              curWrite,
  output logic              reqGrant,
  output busStrobe_t        strb
);

  busState_e stateQ, stateNext;
  logic finalNow, accept, needIdle, curSlow;
  busState_e newFirst, curFirst;

  assign curSlow  = SLOW_MASK[curArea];
  assign newFirst = DRAM_MASK[newArea] ? S_TP : S_T1;
  assign curFirst = DRAM_MASK[curArea] ? S_TP : S_T1;

  assign finalNow = (stateQ == S_T2 && !curSlow) || (stateQ == S_T3) || (stateQ == S_TC2);
  assign reqGrant = (stateQ == S_IDLE) || finalNow;
  assign accept   = reqGrant && reqValid;
  assign needIdle = finalNow && !curWrite && (newArea != curArea) &&
                    (reqWrite ? cfgIdleWR : cfgIdleRR);

  always_comb begin
    stateNext = stateQ;
    if (finalNow) begin
      if (accept) stateNext = needIdle ? S_TI : newFirst;
      else        stateNext = S_IDLE;
    end else begin
      case (stateQ)
        S_IDLE:  stateNext = accept ? newFirst : S_IDLE;
        S_TI:    stateNext = curFirst;
        S_T1:    stateNext = S_T2;
        S_T2:    stateNext = S_T3;
        S_TP:    stateNext = S_TR;
        S_TR:    stateNext = S_TC1;
        S_TC1:   stateNext = S_TC2;
        default: stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateNext;
  end

  always_comb begin
    strb = '0;
    strb.capture = accept;
    case (stateQ)
      S_T1: begin
        strb.driveAddr = 1'b1;
        strb.csOn      = 1'b1;
        strb.rdOn      = !curWrite;
      end
      S_T2, S_T3: begin
        strb.driveAddr = 1'b1;
        strb.csOn      = 1'b1;
        strb.rdOn      = !curWrite;
        strb.wrOn      = curWrite;
      end
      S_TP: strb.driveAddr = 1'b1;
      S_TR: begin
        strb.driveAddr = 1'b1;
        strb.csOn      = 1'b1;
      end
      S_TC1, S_TC2: begin
        strb.driveAddr = 1'b1;
        strb.csOn      = 1'b1;
        strb.rdOn      = !curWrite;
        strb.wrOn      = 1'b1;
      end
      default: strb.driveAddr = 1'b0;
    endcase
  end

  // R5
  idle_after_final_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_TI) |-> $past(finalNow));

  // R3
  no_idle_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_TI) |-> !$past(curWrite));

  // R7
  dram_row_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_TR) |-> ($past(stateQ) == S_TP));

  // R7
  dram_col_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_TC2) |-> ($past(stateQ) == S_TC1));

endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AREA_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  busStrobe_t             strb,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic                   reqWrite,
  input  logic [1:0]             reqBe,
  output logic [AREA_W-1:0]      curArea,
  output logic                   curWrite,
  output logic [ADDR_W-1:0]      busAddr,
  output logic [(1<<AREA_W)-1:0] csN,
  output logic                   rdN,
  output logic                   wrHiN,
  output logic                   wrLoN
);

  localparam int N_AREA = 1 << AREA_W;

  logic [ADDR_W-1:0] addrQ, addrHoldQ;
  logic              writeQ;
  logic [1:0]        beQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      writeQ    <= 1'b0;
      beQ       <= 2'b00;
      addrHoldQ <= '0;
    end else begin
      if (strb.capture) begin
        addrQ  <= reqAddr;
        writeQ <= reqWrite;
        beQ    <= reqBe;
      end
      addrHoldQ <= busAddr;
    end
  end

  assign curArea  = addrQ[ADDR_W-1 -: AREA_W];
  assign curWrite = writeQ;
  assign busAddr  = strb.driveAddr ? addrQ : addrHoldQ;
  assign rdN      = !strb.rdOn;
  assign wrHiN    = !(strb.wrOn && beQ[1]);
  assign wrLoN    = !(strb.wrOn && beQ[0]);

  for (genvar i = 0; i < N_AREA; i++) begin : g_cs
    assign csN[i] = !(strb.csOn && (curArea == AREA_W'(i)));
  end

  // R11
  single_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

endmodule

// File: rtl/xbus_idle_seq.sv
module xbus_idle_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AREA_W = 3,
  parameter logic [(1<<AREA_W)-1:0] DRAM_MASK = 8'h04,
  parameter logic [(1<<AREA_W)-1:0] SLOW_MASK = 8'h20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgIdleRR,
  input  logic                   cfgIdleWR,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [1:0]             reqBe,
  output logic                   reqGrant,
  output logic [ADDR_W-1:0]      busAddr,
  output logic [(1<<AREA_W)-1:0] csN,
  output logic                   rdN,
  output logic                   wrHiN,
  output logic                   wrLoN
);

  busStrobe_t        strb;
  logic [AREA_W-1:0] curArea;
  logic              curWrite;

  xbus_ctrl #(.AREA_W(AREA_W), .DRAM_MASK(DRAM_MASK), .SLOW_MASK(SLOW_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgIdleRR(cfgIdleRR), .cfgIdleWR(cfgIdleWR),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .newArea(reqAddr[ADDR_W-1 -: AREA_W]), .curArea(curArea), .curWrite(curWrite),
    .reqGrant(reqGrant), .strb(strb)
  );

  xbus_dpath #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqBe(reqBe), .curArea(curArea), .curWrite(curWrite), .busAddr(busAddr),
    .csN(csN), .rdN(rdN), .wrHiN(wrHiN), .wrLoN(wrLoN)
  );

endmodule

// File: tb/xbus_idle_seq_test.sv
`timescale 1ns/1ps
module xbus_idle_seq_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgIdleRR = 1'b0, cfgIdleWR = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [1:0] reqBe = 2'b11;
  logic reqGrant, rdN, wrHiN, wrLoN;
  logic [23:0] busAddr;
  logic [7:0] csN;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xbus_idle_seq uut (
    .clk(clk), .rstN(rstN), .cfgIdleRR(cfgIdleRR), .cfgIdleWR(cfgIdleWR),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqBe(reqBe),
    .reqGrant(reqGrant), .busAddr(busAddr), .csN(csN), .rdN(rdN),
    .wrHiN(wrHiN), .wrLoN(wrLoN)
  );

  // trace of outputs, one entry per cycle after the first request is taken
  logic [7:0]  csT [16];
  logic        rdT [16], whT [16], wlT [16], grT [16];
  logic [23:0] adT [16];

  // {writeA, areaA, writeB, areaB, cfgRR, cfgWR, expected idle}
  localparam logic [10:0] VEC [12] = '{
    11'b0_001_0_011_1_0_1,  // R1 on
    11'b0_001_0_011_0_1_0,  // R1 off, R4
    11'b0_001_1_011_0_1_1,  // R2 on
    11'b0_001_1_011_1_0_0,  // R2 off, R4
    11'b0_001_0_001_1_1_0,  // R3 same area
    11'b1_001_0_011_1_1_0,  // R3 after write
    11'b0_001_0_010_1_0_1,  // R8 before DRAM
    11'b0_101_0_000_1_0_1,  // R1 from slow area
    11'b0_010_1_110_0_1_1,  // R2 from DRAM read
    11'b1_010_1_101_1_1_0,  // R3 DRAM write first
    11'b0_100_1_100_1_1_0,  // R3 same area write
    11'b0_110_0_111_0_0_0   // R1 off
  };

  function automatic int lenOf(input logic [2:0] a);
    return (a == 3'd2) ? 4 : (a == 3'd5) ? 3 : 2;
  endfunction

  function automatic logic [23:0] mkAddr(input logic [2:0] a, input logic [7:0] tag);
    return {a, 5'd0, 8'hA0, tag};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sample(input int k);
    csT[k] = csN; rdT[k] = rdN; whT[k] = wrHiN; wlT[k] = wrLoN;
    grT[k] = reqGrant; adT[k] = busAddr;
  endtask

  // called at a negedge with the bus idle
  task automatic runOne(input logic w, input logic [2:0] a, input logic [1:0] be);
    reqValid = 1'b1; reqWrite = w; reqAddr = mkAddr(a, 8'h11); reqBe = be;
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sample(k);
      if (k == 0) reqValid = 1'b0;
    end
  endtask

  task automatic runPair(input logic wA, input logic [2:0] aA,
                         input logic wB, input logic [2:0] aB);
    bit dropNext;
    dropNext = 0;
    reqValid = 1'b1; reqWrite = wA; reqAddr = mkAddr(aA, 8'h01); reqBe = 2'b11;
    @(posedge clk);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k == 0) begin reqWrite = wB; reqAddr = mkAddr(aB, 8'h02); reqBe = 2'b11; end
      sample(k);
      if (dropNext) begin reqValid = 1'b0; dropNext = 0; end
      else if (reqValid && reqGrant) dropNext = 1;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    cfgIdleRR = 1'b1; cfgIdleWR = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    chk("R10 grant", reqGrant, 1);
    chk("R10 selects", csN, 8'hFF);
    chk("R10 strobes", {rdN, wrHiN, wrLoN}, 3'b111);
    chk("R10 address", busAddr, 0);

    // R10 / R3: first request after reset starts at once; R6 static read
    runOne(1'b0, 3'd1, 2'b11);
    chk("R10 no idle after reset", csT[0][1], 0);
    chk("R6 read strobe T1", rdT[0], 0);
    chk("R6 read strobe T2", {csT[1][1], rdT[1]}, 2'b00);
    chk("R6 two states", csT[2], 8'hFF);
    chk("R9 grant in T2 only", {grT[0], grT[1]}, 2'b01);

    // R3: request taken from idle gets no idle state even with both bits set
    runOne(1'b1, 3'd3, 2'b10);
    chk("R3 from idle", csT[0][3], 0);
    chk("R6 write strobes T1", {whT[0], wlT[0]}, 2'b11);
    chk("R6 upper byte T2", {whT[1], wlT[1], rdT[1]}, 3'b011);

    // R6 slow area write
    runOne(1'b1, 3'd5, 2'b11);
    chk("R6 slow T3", {csT[2][5], whT[2], wlT[2]}, 3'b000);
    chk("R6 slow length", csT[3], 8'hFF);

    // R7 DRAM read, lower byte
    runOne(1'b0, 3'd2, 2'b01);
    chk("R7 precharge select", csT[0], 8'hFF);
    chk("R7 precharge address", adT[0], mkAddr(3'd2, 8'h11));
    chk("R7 row", {csT[1][2], wlT[1], rdT[1]}, 3'b011);
    chk("R7 column1", {wlT[2], whT[2], rdT[2]}, 3'b010);
    chk("R7 column2", {csT[3][2], wlT[3], rdT[3]}, 3'b000);
    chk("R7 end", csT[4], 8'hFF);

    // R11 decode of the top area
    runOne(1'b0, 3'd7, 2'b11);
    chk("R11 area 7", csT[0], 8'h7F);

    // table of back-to-back pairs
    for (int i = 0; i < 12; i++) begin
      logic wA, wB, ti;
      logic [2:0] aA, aB;
      int la, expCs, got;
      string tg;
      {wA, aA, wB, aB, cfgIdleRR, cfgIdleWR, ti} = VEC[i];
      runPair(wA, aA, wB, aB);
      la = lenOf(aA);
      tg = (wA || aA == aB) ? "R3" : (aB == 3'd2) ? "R8" : wB ? "R2" : "R1";
      expCs = la + int'(ti) + ((aB == 3'd2) ? 1 : 0);
      got = 99;
      for (int k = 15; k >= la; k--) if (csT[k][aB] == 1'b0) got = k;
      chk($sformatf("%s vec%0d select timing", tg, i), got, expCs);
      chk($sformatf("R5 vec%0d address after final", i), adT[la],
          ti ? mkAddr(aA, 8'h01) : mkAddr(aB, 8'h02));
      if (ti)
        chk($sformatf("R5 vec%0d idle strobes", i),
            {csT[la], rdT[la], whT[la], wlT[la]}, {8'hFF, 3'b111});
      else if (!wA)
        chk($sformatf("R4 vec%0d handoff", i),
            {rdT[la-1], (aB == 3'd2) ? 1'b0 : csT[la][aB]}, 2'b00);
      chk($sformatf("R9 vec%0d grant", i), {grT[la-2], grT[la-1]}, 2'b01);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule